// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block counts two intervals in sequence from a 33 MHz reference clock. The first interval is a warning window. When it runs out, the block sends one warning pulse of a chosen kind and starts the second interval. When the second interval runs out, the block either asks for a system reset and sets a sticky timeout flag, or, if reset is not wanted, goes back to the first interval or stops. Each interval takes its length from its own 20-bit preload. The preload is multiplied by one of two power-of-two scale factors, picked by a single select.

Register decoding sits outside this block. The surrounding logic drives the configuration inputs directly and pulses `reload` whenever software services the watchdog. The block starts counting on a rising edge of `enable`. Taking `enable` low stops it at once.

Top module: `wdt2_core`

## Requirements
- R1: A rising edge of `enable` starts the warning stage (`stage` = 1). When the warning stage expires, the final stage starts (`stage` = 2) and counts the period given by `preload2`.
- R2: A stage started with preload P lasts P·2^5 reference cycles when `fast_scale` = 1 and P·2^15 cycles when `fast_scale` = 0. It expires in that cycle after the start edge. A zero preload expires one cycle after the start.
- R3: When the warning stage expires, `int_type` selects the pulse: 2'd0 gives a one-cycle `irq_pulse`, 2'd2 gives a one-cycle `smi_pulse`, and 2'd1 or 2'd3 give no pulse. The two pulses are never high together.
- R4: When the final stage expires with `reboot_en` = 1, `reset_req` goes high for one cycle and the block returns to its idle, disarmed state (`stage` = 1). Counting resumes only after `enable` goes low and then high again.
- R5: `timeout_flag` is set on the same edge as `reset_req`. It stays set until `rst`.
- R6: When the final stage expires with `reboot_en` = 0, the warning stage starts again if `free_run` = 1. If `free_run` = 0, the block halts in stage 2 and gives no further pulses.
- R7: While the block is enabled and armed, including when halted, `reload` starts the warning stage over with its full period. A reload in the same cycle as an expiry wins, and that expiry has no effect.
- R8: While `enable` = 0, nothing counts, `reload` is ignored, no pulse is produced and `stage` reads 1. Taking `enable` low stops a running stage on the next edge.
- R9: After reset, all pulses and the flag are 0 and `stage` is 1.
- R10: Each stage's period is captured when the stage starts. Changing a preload afterwards does not change a stage that is already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 33 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Rising edge arms the block and starts counting; low stops it |
| reload | input | 1 | Service strobe that restarts the warning stage |
| fast_scale | input | 1 | 1: period = preload·32, 0: period = preload·32768 |
| preload1 | input | 20 | Warning stage preload |
| preload2 | input | 20 | Final stage preload |
| int_type | input | 2 | Warning kind: 0 IRQ, 2 SMI, 1/3 none |
| reboot_en | input | 1 | Final-stage expiry requests a reset |
| free_run | input | 1 | Without reboot, restart the warning stage after the final stage |
| irq_pulse | output | 1 | One-cycle warning interrupt |
| smi_pulse | output | 1 | One-cycle system-management warning |
| reset_req | output | 1 | One-cycle reset request |
| timeout_flag | output | 1 | Sticky flag: a reset was requested |
| stage | output | 2 | Current stage, 1 or 2 |

## Verification
The assertions assume that `rst` is asserted from time zero and that the configuration inputs change only between clock edges. The bench drives every input on the falling edge, so the design samples settled values. The scenarios assume the periods are short enough to observe, so the bench mostly uses the fast scale with preloads of 0 to 3. A single slow-scale run checks the long shift. Reloads and preload changes are placed at counted edges relative to the start edge, so the collision between a reload and an expiry happens exactly, not by chance.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int DEF_PRELOAD_W = 20;
    localparam int DEF_SLOW_SHIFT = 15;
    localparam int DEF_FAST_SHIFT = 5;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_WARN  = 2'd1,
        PH_FINAL = 2'd2,
        PH_HALT  = 2'd3
    } phase_e;

    typedef struct packed {
        logic irq;
        logic smi;
    } alert_t;

    // Warning kind: code 0 -> interrupt, code 2 -> management event, others silent
    function automatic alert_t alert_of(input logic fire, input logic [1:0] kind);
        alert_t a;
        a.irq = fire && (kind == 2'd0);
        a.smi = fire && (kind == 2'd2);
        return a;
    endfunction

endpackage

// File: rtl/wdt2_period.sv
module wdt2_period #(
    parameter int PRELOAD_W  = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5,
    parameter int CNT_W      = PRELOAD_W + SLOW_SHIFT + 1
) (
    input  logic [PRELOAD_W-1:0] preload,
    input  logic                 fast,
    output logic [CNT_W-1:0]     period
);
    logic [CNT_W-1:0] wide;

    always_comb begin
        wide   = CNT_W'(preload);
        period = fast ? (wide << FAST_SHIFT) : (wide << SLOW_SHIFT);
    end
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt > ONE)
            cnt <= cnt - ONE;
    end

    assign expire = run && (cnt <= ONE);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
    import wdt2_pkg::*;
#(
    parameter int PRELOAD_W  = DEF_PRELOAD_W,
    parameter int SLOW_SHIFT = DEF_SLOW_SHIFT,
    parameter int FAST_SHIFT = DEF_FAST_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 reload,
    input  logic                 fast_scale,
    input  logic [PRELOAD_W-1:0] preload1,
    input  logic [PRELOAD_W-1:0] preload2,
    input  logic [1:0]           int_type,
    input  logic                 reboot_en,
    input  logic                 free_run,
    output logic                 irq_pulse,
    output logic                 smi_pulse,
    output logic                 reset_req,
    output logic                 timeout_flag,
    output logic [1:0]           stage
);
    localparam int CNT_W = PRELOAD_W + SLOW_SHIFT + 1;
    localparam int N_STAGES = 2;

    phase_e           phase;
    logic             en_q;
    logic             en_rise, start1, running, ctr_expire;
    logic             warn_done, final_done, ctr_load;
    logic [CNT_W-1:0] ctr_val;
    alert_t           alert;

    logic [PRELOAD_W-1:0] pl  [N_STAGES];
    logic [CNT_W-1:0]     per [N_STAGES];

    assign pl[0] = preload1;
    assign pl[1] = preload2;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_per
        wdt2_period #(
            .PRELOAD_W (PRELOAD_W),
            .SLOW_SHIFT(SLOW_SHIFT),
            .FAST_SHIFT(FAST_SHIFT),
            .CNT_W     (CNT_W)
        ) u_per (
            .preload(pl[g]),
            .fast   (fast_scale),
            .period (per[g])
        );
    end

    always_comb begin
        en_rise    = enable && !en_q;
        running    = (phase == PH_WARN) || (phase == PH_FINAL);
        start1     = enable && (en_rise || (reload && phase != PH_OFF));
        warn_done  = enable && !start1 && (phase == PH_WARN) && ctr_expire;
        final_done = enable && !start1 && (phase == PH_FINAL) && ctr_expire;
        ctr_load   = start1 || warn_done || (final_done && !reboot_en && free_run);
        ctr_val    = warn_done ? per[1] : per[0];
        alert      = alert_of(warn_done, int_type);
    end

    wdt2_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (ctr_load),
        .load_val(ctr_val),
        .run     (enable && running),
        .expire  (ctr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_OFF;
            en_q         <= 1'b0;
            irq_pulse    <= 1'b0;
            smi_pulse    <= 1'b0;
            reset_req    <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            en_q      <= enable;
            irq_pulse <= alert.irq;
            smi_pulse <= alert.smi;
            reset_req <= final_done && reboot_en;
            if (final_done && reboot_en)
                timeout_flag <= 1'b1;

            if (!enable)
                phase <= PH_OFF;
            else if (start1)
                phase <= PH_WARN;
            else if (warn_done)
                phase <= PH_FINAL;
            else if (final_done)
                phase <= reboot_en ? PH_OFF : (free_run ? PH_WARN : PH_HALT);
        end
    end

    assign stage = (phase == PH_FINAL || phase == PH_HALT) ? 2'd2 : 2'd1;

    assert_alert_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(irq_pulse && smi_pulse));
    assert_warn_enters_final_R1: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || smi_pulse) |-> stage == 2'd2);
    assert_reset_single_R4: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (!reset_req && stage == 2'd1));
    assert_reset_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> timeout_flag);
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> timeout_flag);
    assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!irq_pulse && !smi_pulse && !reset_req && stage == 2'd1));
endmodule

// File: tb/wdt2_core_test.sv
module wdt2_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, reload = 1'b0, fast_scale = 1'b1;
    logic [19:0] preload1 = 20'd1, preload2 = 20'd1;
    logic [1:0]  int_type = 2'd0;
    logic        reboot_en = 1'b0, free_run = 1'b0;
    logic        irq_pulse, smi_pulse, reset_req, timeout_flag;
    logic [1:0]  stage;

    int errs = 0, checks = 0, cyc = 0;
    int irq_seen = 0, smi_seen = 0, rst_seen = 0;

    always #2 clk = ~clk;

    wdt2_core uut (
        .clk(clk), .rst(rst), .enable(enable), .reload(reload),
        .fast_scale(fast_scale), .preload1(preload1), .preload2(preload2),
        .int_type(int_type), .reboot_en(reboot_en), .free_run(free_run),
        .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reset_req(reset_req),
        .timeout_flag(timeout_flag), .stage(stage)
    );

    // Behavioural reference: remaining-cycle count per stage
    int     m_mode = 0;          // 0 idle, 1 warning, 2 final, 3 halted
    longint m_left = 0;
    bit     m_enq = 0, m_flag = 0, m_irq = 0, m_smi = 0, m_rst = 0;

    function automatic longint span(input logic [19:0] p, input logic f);
        longint v = f ? (longint'(p) * 32) : (longint'(p) * 32768);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        bit rise;
        m_irq = 0; m_smi = 0; m_rst = 0;
        if (rst) begin
            m_mode = 0; m_enq = 0; m_flag = 0; m_left = 0;
        end else begin
            rise  = enable && !m_enq;
            m_enq = enable;
            if (!enable) m_mode = 0;
            else if (rise || (reload && m_mode != 0)) begin
                m_mode = 1; m_left = span(preload1, fast_scale);
            end else if (m_mode == 1 || m_mode == 2) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 1) begin
                        m_irq = (int_type == 2'd0);
                        m_smi = (int_type == 2'd2);
                        m_mode = 2; m_left = span(preload2, fast_scale);
                    end else if (reboot_en) begin
                        m_flag = 1; m_rst = 1; m_mode = 0;
                    end else if (free_run) begin
                        m_mode = 1; m_left = span(preload1, fast_scale);
                    end else m_mode = 3;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, after the edge has settled
    always @(posedge clk) begin
        #1;
        if (irq_pulse) irq_seen++;
        if (smi_pulse) smi_seen++;
        if (reset_req) rst_seen++;
        chk(irq_pulse == m_irq, "R3 irq_pulse", irq_pulse, m_irq);
        chk(smi_pulse == m_smi, "R3 smi_pulse", smi_pulse, m_smi);
        chk(reset_req == m_rst, "R4 reset_req", reset_req, m_rst);
        chk(timeout_flag == m_flag, "R5 timeout_flag", timeout_flag, m_flag);
        chk(stage == ((m_mode >= 2) ? 2'd2 : 2'd1), "R1 stage", stage, (m_mode >= 2) ? 2 : 1);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errs++;
            $display("FAIL R9 watchdog: actual=%0d cycles expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        @(negedge clk) enable = 1'b0;
        @(negedge clk) enable = 1'b1;
    endtask

    // Count rising edges (from the next one) until the selected output is high
    task automatic edges_until(input int which, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!((which == 0 && irq_pulse) || (which == 1 && reset_req)) && n < 40000);
    endtask

    initial begin
        int n, base_irq, base_smi, base_rst;
        ticks(3);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(irq_pulse == 0 && smi_pulse == 0 && reset_req == 0, "R9 pulses", {irq_pulse, smi_pulse, reset_req}, 0);
        chk(timeout_flag == 0, "R9 flag", timeout_flag, 0);
        chk(stage == 1, "R9 stage", stage, 1);

        // R2/R4: fast scale, warning then reboot
        @(negedge clk);
        fast_scale = 1; preload1 = 20'd1; preload2 = 20'd2; int_type = 2'd0; reboot_en = 1;
        enable = 1'b1;
        edges_until(0, n);
        chk(n == 33, "R2 fast warning length", n, 33);
        chk(stage == 2, "R1 stage after warning", stage, 2);
        edges_until(1, n);
        chk(n == 64, "R1 final stage uses preload2", n, 64);
        chk(timeout_flag == 1, "R5 flag set with reset", timeout_flag, 1);
        @(posedge clk); #1;
        chk(stage == 1, "R4 back to idle", stage, 1);
        base_irq = irq_seen; base_rst = rst_seen;
        ticks(80);
        chk(irq_seen == base_irq && rst_seen == base_rst, "R4 no restart while enable held",
            irq_seen - base_irq, 0);

        // R6/R3: free run, SMI kind, zero preloads
        reboot_en = 0; free_run = 1; int_type = 2'd2; preload1 = 0; preload2 = 0;
        arm();
        base_smi = smi_seen;
        ticks(20);
        chk(smi_seen - base_smi == 10, "R6 free-run repeats, R2 zero preload", smi_seen - base_smi, 10);
        base_irq = irq_seen; base_smi = smi_seen;
        int_type = 2'd3;
        ticks(12);
        int_type = 2'd1;
        ticks(12);
        chk(irq_seen == base_irq && smi_seen == base_smi, "R3 silent kinds", irq_seen + smi_seen - base_irq - base_smi, 0);

        // R6 halt then R7 reload from halt
        free_run = 0; int_type = 2'd0;
        arm();
        ticks(10);
        chk(stage == 2, "R6 halted in stage 2", stage, 2);
        base_irq = irq_seen;
        ticks(20);
        chk(irq_seen == base_irq, "R6 no pulses while halted", irq_seen - base_irq, 0);
        reload = 1;
        @(negedge clk) reload = 0;
        chk(stage == 1, "R7 reload leaves halt", stage, 1);

        // R7: reload colliding with warning expiry
        preload1 = 20'd1; preload2 = 20'd3;
        arm();
        ticks(32);
        reload = 1;
        @(negedge clk) reload = 0;
        edges_until(0, n);
        chk(n == 32, "R7 reload beats expiry, full period", n, 32);

        // R8: disabled stops counting; reload ignored
        arm();
        ticks(10);
        enable = 0;
        base_irq = irq_seen;
        ticks(5);
        reload = 1;
        ticks(3);
        reload = 0;
        ticks(60);
        chk(irq_seen == base_irq, "R8 disabled stays quiet", irq_seen - base_irq, 0);
        chk(stage == 1, "R8 disabled stage", stage, 1);

        // R10: preload change mid-stage
        preload1 = 20'd2;
        @(negedge clk) enable = 1;
        ticks(10);
        preload1 = 20'd1;
        edges_until(0, n);
        chk(n == 55, "R10 period captured at start", n, 55);

        // R2 slow scale, zero final stage, then halt
        preload1 = 20'd1; preload2 = 20'd0; fast_scale = 0;
        arm();
        edges_until(0, n);
        chk(n == 32769, "R2 slow warning length", n, 32769);
        ticks(4);
        chk(stage == 2, "R6 halted after zero final stage", stage, 2);

        // R5: flag cleared only by reset
        chk(timeout_flag == 1, "R5 flag still set", timeout_flag, 1);
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        chk(timeout_flag == 0, "R5 flag cleared by rst", timeout_flag, 0);

        ticks(2);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule